// File: doc/BRIEF.md
# PHY Event Counter and Interrupt Register Pair

This block holds two management registers of an Ethernet PHY. The first counts false-carrier events in an 8-bit field that saturates instead of wrapping and clears when read. The second register has two parts. Its upper half holds latched pending flags, one for each receive-side event source and one for the counter's half-scale crossing. Its lower half holds the enables that decide which pending flags may drive the interrupt line. Pending flags clear when the register is read.

The receive logic supplies single-cycle event pulses. A management agent accesses the registers through a flat interface made of an address, a read strobe, a write strobe and 16-bit data. Read data is combinational and is valid in the cycle the read strobe is high. Any clearing caused by that read takes effect at the clock edge that ends the cycle. Reset is synchronous and active-low.

Top module: `phy_evt_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, every pending flag and every enable go to zero, and `irq` is low after that edge.
- R2: Each cycle with `ev_false_carrier` high raises the count by one. Reading address 0x14 returns the count in bits 7:0, and bits 15:8 read as zero.
- R3: The count stops at 0xFF. Further false-carrier pulses leave it at 0xFF.
- R4: A read of address 0x14 returns the current count and leaves the count at zero. If a false-carrier pulse arrives in the same cycle as that read, the count becomes 1.
- R5: A false-carrier pulse that moves the count from 0x7F to 0x80 sets the half-scale pending flag at bit 15 of address 0x13. This flag has no enable bit and always drives `irq`.
- R6: Event pulses set pending flags at address 0x13 in these bits: 14 auto-negotiation error, 13 page received, 12 loopback FIFO over/underflow, 11 crossover change, 10 sleep event, 9 polarity change, 8 jabber. A read of 0x13 returns the flags and then clears them. A pulse arriving in the same cycle as that read leaves its own flag set.
- R7: Bits 6:0 of address 0x13 are read/write enables. Bit i gates pending bit 8+i. Bit 7 always reads as 0.
- R8: `irq` is high exactly when the half-scale flag is set, or when some event flag is set and its enable is set.
- R9: Writes have no effect on the count, on the pending flags or on bit 7 of address 0x13. A read of any address other than 0x13 or 0x14 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational, zero when not reading |
| ev_false_carrier | input | 1 | False-carrier event pulse |
| ev_an_error | input | 1 | Auto-negotiation error pulse |
| ev_page_rx | input | 1 | Page received pulse |
| ev_lpbk_fifo | input | 1 | Loopback FIFO over/underflow pulse |
| ev_xover | input | 1 | Crossover status change pulse |
| ev_sleep | input | 1 | Sleep-mode event pulse |
| ev_polarity | input | 1 | Polarity change pulse |
| ev_jabber | input | 1 | Jabber detection pulse |
| irq | output | 1 | Interrupt request |

## Verification
Clear-on-read can fall in the same cycle as a new event. This applies to the counter and to the pending flags. The bench provokes both cases by pulsing an event in the very cycle it reads the register. It then judges the result in two places: the returned data must hold the value from before the read, and a follow-up read must show either a count of 1 or the new flag still set.

// File: rtl/phy_evt_pkg.sv
// Package: shared constants for the PHY event register pair.
// Assumes a 16-bit management data path and seven maskable event sources.
package phy_evt_pkg;
    localparam int DATA_W   = 16;
    localparam int N_SRC    = 7;   // maskable event sources
    localparam int N_PEND   = N_SRC + 1; // plus half-scale flag
    localparam int PEND_LSB = 8;   // pending flags start at bit 8

    // Index of each maskable source; pending bit = PEND_LSB + index
    typedef enum int {
        SRC_JABBER   = 0,
        SRC_POLARITY = 1,
        SRC_SLEEP    = 2,
        SRC_XOVER    = 3,
        SRC_LPBK     = 4,
        SRC_PAGE     = 5,
        SRC_ANERR    = 6,
        SRC_HALF     = 7
    } evt_src_e;
endpackage

// File: rtl/evt_sat_counter.sv
// Module: saturating event counter with clear-on-read.
// Counts increment pulses, holds at all-ones, and reports the exact
// increment that crosses half scale. A clear in the same cycle as an
// increment leaves a count of one. Assumes synchronous active-low reset.
module evt_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             half_cross
);
    localparam logic [CNT_W-1:0] MAX_VAL  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HALF_LO  = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_max;
    logic [CNT_W-1:0] count_nx;

    // Purpose: detect the saturation point
    always_comb at_max = (count == MAX_VAL);

    // Purpose: flag the increment moving the count past half scale
    always_comb half_cross = inc && !clr && (count == HALF_LO);

    // Purpose: choose the next count from clear, increment and saturation
    always_comb begin
        if (clr)
            count_nx = inc ? ONE : '0;
        else if (inc && !at_max)
            count_nx = count + ONE;
        else
            count_nx = count;
    end

    // Purpose: hold the count
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= count_nx;
    end
endmodule

// File: rtl/evt_pending_bank.sv
// Module: bank of latched pending flags with clear-on-read.
// Each flag sets on its pulse and clears on a bank-wide clear, but a pulse
// in the clearing cycle wins so no event is lost. Synchronous active-low reset.
module evt_pending_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: latch one pending flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (set[i])
                pend[i] <= 1'b1;
            else if (clr)
                pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_enable_reg.sv
// Module: read/write interrupt enable bits.
// Loads all enables on a write strobe. Synchronous active-low reset to zero.
module evt_enable_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en
);
    // Purpose: store enables written by the management agent
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= '0;
        else if (wr)
            en <= wdata;
    end
endmodule

// File: rtl/phy_evt_regs.sv
// Module: false-carrier counter and interrupt status/enable registers.
// Decodes a flat register access, clears on read, masks pending flags with
// enables and raises irq. Assumes reads are single-cycle strobes and that
// the status layout fits 16 bits. Synchronous active-low reset.
module phy_evt_regs
    import phy_evt_pkg::*;
#(
    parameter int              ADDR_W    = 5,
    parameter int              CNT_W     = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h13,
    parameter logic [ADDR_W-1:0] CNT_ADDR  = 5'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_false_carrier,
    input  logic              ev_an_error,
    input  logic              ev_page_rx,
    input  logic              ev_lpbk_fifo,
    input  logic              ev_xover,
    input  logic              ev_sleep,
    input  logic              ev_polarity,
    input  logic              ev_jabber,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic              sel_stat, sel_cnt;
    logic              rd_stat, rd_cnt, wr_stat;
    logic [CNT_W-1:0]  fc_count;
    logic              half_cross;
    logic [N_PEND-1:0] pend_set, pend;
    logic [N_SRC-1:0]  en_q;

    // Purpose: decode address selects and access strobes
    always_comb begin
        sel_stat = (reg_addr == STAT_ADDR);
        sel_cnt  = (reg_addr == CNT_ADDR);
        rd_stat  = reg_rd && sel_stat;
        rd_cnt   = reg_rd && sel_cnt;
        wr_stat  = reg_wr && sel_stat;
    end

    // Purpose: gather event pulses into pending-bank order
    always_comb begin
        pend_set               = '0;
        pend_set[SRC_JABBER]   = ev_jabber;
        pend_set[SRC_POLARITY] = ev_polarity;
        pend_set[SRC_SLEEP]    = ev_sleep;
        pend_set[SRC_XOVER]    = ev_xover;
        pend_set[SRC_LPBK]     = ev_lpbk_fifo;
        pend_set[SRC_PAGE]     = ev_page_rx;
        pend_set[SRC_ANERR]    = ev_an_error;
        pend_set[SRC_HALF]     = half_cross;
    end

    evt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (ev_false_carrier),
        .clr        (rd_cnt),
        .count      (fc_count),
        .half_cross (half_cross)
    );

    evt_pending_bank #(.N(N_PEND)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pend_set),
        .clr   (rd_stat),
        .pend  (pend)
    );

    evt_enable_reg #(.N(N_SRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_stat),
        .wdata (reg_wdata[N_SRC-1:0]),
        .en    (en_q)
    );

    // Purpose: return read data; reserved bits and idle cycles read zero
    always_comb begin
        if (rd_stat)
            reg_rdata = {pend, 1'b0, en_q};
        else if (rd_cnt)
            reg_rdata = {{PAD_W{1'b0}}, fc_count};
        else
            reg_rdata = '0;
    end

    // Purpose: interrupt from masked flags; half-scale flag is unmasked
    always_comb irq = |(pend & {1'b1, en_q});
endmodule

// File: rtl/phy_evt_regs_chk.sv
// Module: property checker for phy_evt_regs, bound to every instance.
// Observes ports plus the count, pending and enable state of the top.
module phy_evt_regs_chk #(
    parameter int              ADDR_W    = 5,
    parameter int              CNT_W     = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h13,
    parameter logic [ADDR_W-1:0] CNT_ADDR  = 5'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [15:0]       reg_rdata,
    input logic              ev_false_carrier,
    input logic              ev_polarity,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [7:0]        pend,
    input logic [6:0]        en
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HLO  = {1'b0, {(CNT_W-1){1'b1}}};

    logic rdc, rds;
    always_comb begin
        rdc = reg_rd && (reg_addr == CNT_ADDR);
        rds = reg_rd && (reg_addr == STAT_ADDR);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdc && ev_false_carrier && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1); // R2
    AST_CNT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdc |-> reg_rdata[15:8] == 8'h00); // R2
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdc && cnt == MAXV) |=> cnt == MAXV); // R3
    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rdc |=> cnt == ($past(ev_false_carrier) ? 1 : 0)); // R4
    AST_HALF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdc && ev_false_carrier && cnt == HLO) |=> pend[7] && irq); // R5
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rds && ev_polarity) |=> pend[1]); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rds |-> !reg_rdata[7]); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 8'h00) |-> !irq); // R8
    AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 7'h00 && !pend[7]) |-> !irq); // R7
    AST_RO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && !ev_false_carrier) |=> cnt == $past(cnt)); // R9
endmodule

bind phy_evt_regs phy_evt_regs_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAT_ADDR(STAT_ADDR), .CNT_ADDR(CNT_ADDR)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_addr         (reg_addr),
    .reg_rd           (reg_rd),
    .reg_wr           (reg_wr),
    .reg_rdata        (reg_rdata),
    .ev_false_carrier (ev_false_carrier),
    .ev_polarity      (ev_polarity),
    .irq              (irq),
    .cnt              (fc_count),
    .pend             (pend),
    .en               (en_q)
);

// File: tb/tb_phy_evt_regs.sv
// Bench: vector table walked by one loop, then directed reset and
// saturation tests. Results are counted; one summary line at the end.
module tb_phy_evt_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  ev = '0; // 7 fc,6 an,5 page,4 fifo,3 xover,2 sleep,1 pol,0 jab
    logic        irq;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    phy_evt_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_false_carrier(ev[7]), .ev_an_error(ev[6]), .ev_page_rx(ev[5]),
        .ev_lpbk_fifo(ev[4]), .ev_xover(ev[3]), .ev_sleep(ev[2]),
        .ev_polarity(ev[1]), .ev_jabber(ev[0]), .irq(irq)
    );

    // op: 0 idle/events, 1 read, 2 write | addr | wdata | events | exp rdata | exp irq | req
    localparam int NV = 18;
    localparam logic [51:0] VECS [0:NV-1] = '{
        {2'd2, 5'h13, 16'hFFFF, 8'h00, 16'h0000, 1'b0, 4'd7}, // R7 write all enables
        {2'd1, 5'h13, 16'h0000, 8'h00, 16'h007F, 1'b0, 4'd7}, // R7 bit 7 reads 0
        {2'd0, 5'h00, 16'h0000, 8'h01, 16'h0000, 1'b1, 4'd8}, // R8 jabber enabled
        {2'd1, 5'h13, 16'h0000, 8'h02, 16'h017F, 1'b1, 4'd6}, // R6 read + polarity same cycle
        {2'd1, 5'h13, 16'h0000, 8'h00, 16'h027F, 1'b0, 4'd6}, // R6 polarity survived
        {2'd2, 5'h13, 16'h0000, 8'h00, 16'h0000, 1'b0, 4'd7}, // R7 disable all
        {2'd0, 5'h00, 16'h0000, 8'h40, 16'h0000, 1'b0, 4'd7}, // R7 masked an-error
        {2'd1, 5'h13, 16'h0000, 8'h00, 16'h4000, 1'b0, 4'd6}, // R6 an-error bit 14
        {2'd0, 5'h00, 16'h0000, 8'h80, 16'h0000, 1'b0, 4'd2}, // R2 count
        {2'd0, 5'h00, 16'h0000, 8'h80, 16'h0000, 1'b0, 4'd2},
        {2'd0, 5'h00, 16'h0000, 8'h80, 16'h0000, 1'b0, 4'd2},
        {2'd1, 5'h14, 16'h0000, 8'h80, 16'h0003, 1'b0, 4'd4}, // R4 read + event
        {2'd1, 5'h14, 16'h0000, 8'h00, 16'h0001, 1'b0, 4'd4}, // R4 count became 1
        {2'd2, 5'h14, 16'hFFFF, 8'h00, 16'h0000, 1'b0, 4'd9}, // R9 write counter
        {2'd1, 5'h14, 16'h0000, 8'h00, 16'h0000, 1'b0, 4'd9}, // R9 unchanged
        {2'd2, 5'h13, 16'hFF80, 8'h00, 16'h0000, 1'b0, 4'd9}, // R9 write RO bits
        {2'd1, 5'h13, 16'h0000, 8'h00, 16'h0000, 1'b0, 4'd9}, // R9 nothing latched
        {2'd1, 5'h10, 16'h0000, 8'h00, 16'h0000, 1'b0, 4'd9}  // R9 other address
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access cycle: drive at negedge, sample read data, sample irq after the edge
    task automatic cyc(input logic [1:0] op, input logic [4:0] a, input logic [15:0] d,
                       input logic [7:0] e, output logic [15:0] rd, output logic iq);
        @(negedge clk);
        reg_addr = a; reg_rd = (op == 2'd1); reg_wr = (op == 2'd2);
        reg_wdata = d; ev = e;
        #1 rd = reg_rdata;
        @(posedge clk);
        #1 iq = irq;
        reg_rd = 1'b0; reg_wr = 1'b0; ev = '0;
    endtask

    initial begin : watchdog
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] rd;
        logic iq;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq after reset", {15'd0, irq}, 16'h0);
        cyc(2'd1, 5'h13, 16'h0, 8'h0, rd, iq); chk("R1 status after reset", rd, 16'h0);
        cyc(2'd1, 5'h14, 16'h0, 8'h0, rd, iq); chk("R1 count after reset", rd, 16'h0);

        for (int i = 0; i < NV; i++) begin
            logic [51:0] v;
            v = VECS[i];
            cyc(v[51:50], v[49:45], v[44:29], v[28:21], rd, iq);
            if (v[51:50] == 2'd1)
                chk($sformatf("R%0d vec%0d rdata", v[3:0], i), rd, v[20:5]);
            chk($sformatf("R%0d vec%0d irq", v[3:0], i), {15'd0, iq}, {15'd0, v[4]});
        end

        // R5 half-scale crossing with all enables off
        for (int i = 0; i < 127; i++) cyc(2'd0, 5'h0, 16'h0, 8'h80, rd, iq);
        chk("R5 no irq at 0x7F", {15'd0, iq}, 16'h0);
        cyc(2'd0, 5'h0, 16'h0, 8'h80, rd, iq);
        chk("R5 irq at 0x80", {15'd0, iq}, 16'h1);
        // R3 saturation
        for (int i = 0; i < 200; i++) cyc(2'd0, 5'h0, 16'h0, 8'h80, rd, iq);
        cyc(2'd1, 5'h14, 16'h0, 8'h0, rd, iq); chk("R3 saturated count", rd, 16'h00FF);
        cyc(2'd1, 5'h14, 16'h0, 8'h0, rd, iq); chk("R4 cleared after read", rd, 16'h0);
        cyc(2'd1, 5'h13, 16'h0, 8'h0, rd, iq); chk("R5 half flag bit 15", rd, 16'h8000);
        chk("R8 irq dropped after status read", {15'd0, iq}, 16'h0);

        // R1 mid-run reset clears enables and flags
        cyc(2'd2, 5'h13, 16'h007F, 8'h0, rd, iq);
        cyc(2'd0, 5'h0, 16'h0, 8'h82, rd, iq);
        chk("R8 polarity irq before reset", {15'd0, iq}, 16'h1);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk("R1 irq after mid reset", {15'd0, irq}, 16'h0);
        cyc(2'd1, 5'h13, 16'h0, 8'h0, rd, iq); chk("R1 status after mid reset", rd, 16'h0);
        cyc(2'd1, 5'h14, 16'h0, 8'h0, rd, iq); chk("R1 count after mid reset", rd, 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule